// File: doc/BRIEF.md
# Scan Chain Flush Test Controller

This controller checks an external scan shift register before any scan test vectors go through it. On a start request it holds the chain's test control in shift mode for a fixed number of clocks. It drives a repeating two-zeros, two-ones bit stream into the chain's serial input. It then compares the chain's serial output against the same stream, delayed by the chain length. Over the stream, every cell of the chain sees all four bit-to-bit transitions: 0 to 0, 0 to 1, 1 to 1 and 1 to 0.

The chain length is a parameter. The run lasts that length plus four shift clocks. Only the last four clocks are compared, because before then the output still holds whatever the chain contained before the run. At the end the block raises a one-cycle completion pulse. It holds a pass flag and a saturating mismatch count until the next start. Locating a failing cell is left to later scan diagnosis.

Top module: `scan_flush_ctrl`

## Requirements
- R1: After reset, `scan_en_o`, `scan_in_o`, `done_o` and `pass_o` are 0 and `miss_cnt_o` is 0.
- R2: One cycle after `start_i` is sampled high, `scan_en_o` is 1. It stays 1 for exactly CHAIN_LEN+4 consecutive cycles and then falls to 0.
- R3: During a run, `scan_in_o` in run cycle k (k = 0 for the first cycle with `scan_en_o` high) is 1 when k mod 4 is 2 or 3, and 0 otherwise. The stream therefore begins 0,0,1,1,0,0,...
- R4: `scan_out_i` is compared only in run cycles k >= CHAIN_LEN, against the bit driven in cycle k-CHAIN_LEN. Each unequal comparison adds one to `miss_cnt_o`, and earlier chain contents have no effect. With that scheme, a cell stuck at 0 or at 1 gives 2 mismatches, an inverted output gives 4, and a chain one cell short gives 2.
- R5: `miss_cnt_o` saturates at 2^MISS_W-1 and does not wrap.
- R6: `done_o` is 1 for exactly one cycle, in the cycle right after the last run cycle. In that cycle `scan_en_o` is 0.
- R7: `pass_o` rises together with `done_o` only if the run had zero mismatches. `pass_o` and `miss_cnt_o` then hold until the next start.
- R8: `start_i` sampled high at any time, including during a run, restarts the stream at k = 0 and clears `miss_cnt_o` and `pass_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin or restart a flush run |
| scan_out_i | input | 1 | Serial output of the chain under test |
| scan_en_o | output | 1 | Test control to the chain: 1 selects shift mode |
| scan_in_o | output | 1 | Serial input to the chain |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Run finished with no mismatches |
| miss_cnt_o | output | MISS_W | Saturating mismatch count of the last or current run |

## Verification
The assertions check properties that hold every cycle: the stream's period-four shape, since each bit is the inverse of the bit two cycles before inside an uninterrupted run; the single-cycle completion pulse that always follows shift mode; a pass flag that never coexists with a nonzero count; and a count that never decreases without a start. Only the bench's scenarios can show the exact run length, the timing of the compare window relative to the chain length, and the mismatch totals that stuck cells, an inverted output or a short chain produce. The same holds for saturation in a narrow counter and for a restart in the middle of a run.

// File: rtl/scan_flush_pkg.sv
package scan_flush_pkg;

  typedef enum logic [1:0] {
    FL_IDLE = 2'd0,
    FL_RUN  = 2'd1,
    FL_DONE = 2'd2
  } fl_state_e;

  // Stream bit for a phase position: phases 2 and 3 drive a one.
  function automatic logic pat_bit(input logic [1:0] ph);
    return ph[1];
  endfunction

endpackage

// File: rtl/scan_flush_seq.sv
module scan_flush_seq
  import scan_flush_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic run_o,
  output logic done_o,
  output logic last_o,
  output logic cmp_en_o,
  output logic exp_bit_o
);

  localparam int RUN_LEN = CHAIN_LEN + 4;
  localparam int CW      = $clog2(RUN_LEN) + 1;
  localparam logic [CW-1:0] LAST_K  = CW'(RUN_LEN - 1);
  localparam logic [CW-1:0] WIN_K   = CW'(CHAIN_LEN);
  localparam logic [1:0]    LEN_LO  = 2'(CHAIN_LEN % 4);

  fl_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (start_i) begin
      state_d = FL_RUN;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      case (state_q)
        FL_RUN: begin
          cnt_en = 1'b1;
          if (cnt_q == LAST_K) begin
            state_d = FL_DONE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        FL_DONE: state_d = FL_IDLE;
        default: state_d = FL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FL_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign run_o     = (state_q == FL_RUN);
  assign done_o    = (state_q == FL_DONE);
  assign last_o    = run_o && (cnt_q == LAST_K);
  assign cmp_en_o  = run_o && (cnt_q >= WIN_K);
  // Bit driven CHAIN_LEN cycles ago has phase (k - CHAIN_LEN) mod 4.
  assign exp_bit_o = pat_bit(cnt_q[1:0] - LEN_LO);

endmodule

// File: rtl/scan_flush_pat.sv
module scan_flush_pat
  import scan_flush_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic scan_in_o
);

  logic [1:0] phase_q, phase_d;
  logic       phase_en;

  always_comb begin
    phase_en = start_i || run_i;
    phase_d  = start_i ? 2'd0 : phase_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  assign scan_in_o = run_i && pat_bit(phase_q);

endmodule

// File: rtl/scan_flush_tally.sv
module scan_flush_tally #(
  parameter int MISS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_en_i,
  input  logic              exp_bit_i,
  input  logic              scan_out_i,
  input  logic              last_i,
  output logic              pass_o,
  output logic [MISS_W-1:0] miss_cnt_o
);

  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  logic [MISS_W-1:0] miss_q, miss_d;
  logic              fail_q, fail_d;
  logic              fin_q, fin_d;
  logic              miss_hit;

  always_comb begin
    miss_hit = cmp_en_i && (scan_out_i != exp_bit_i);
    miss_d   = miss_q;
    fail_d   = fail_q;
    fin_d    = fin_q;
    if (start_i) begin
      miss_d = '0;
      fail_d = 1'b0;
      fin_d  = 1'b0;
    end else begin
      if (miss_hit) begin
        fail_d = 1'b1;
        if (miss_q != MISS_MAX) begin
          miss_d = miss_q + 1'b1;
        end
      end
      if (last_i) begin
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= '0;
      fail_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      miss_q <= miss_d;
      fail_q <= fail_d;
      fin_q  <= fin_d;
    end
  end

  assign pass_o     = fin_q && !fail_q;
  assign miss_cnt_o = miss_q;

endmodule

// File: rtl/scan_flush_ctrl.sv
module scan_flush_ctrl #(
  parameter int CHAIN_LEN = 8,
  parameter int MISS_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              scan_out_i,
  output logic              scan_en_o,
  output logic              scan_in_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [MISS_W-1:0] miss_cnt_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       run, last, cmp_en, exp_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  scan_flush_seq #(.CHAIN_LEN(CHAIN_LEN)) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .run_o     (run),
    .done_o    (done_o),
    .last_o    (last),
    .cmp_en_o  (cmp_en),
    .exp_bit_o (exp_bit)
  );

  scan_flush_pat i_pat (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .run_i     (run),
    .scan_in_o (scan_in_o)
  );

  scan_flush_tally #(.MISS_W(MISS_W)) i_tally (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .cmp_en_i   (cmp_en),
    .exp_bit_i  (exp_bit),
    .scan_out_i (scan_out_i),
    .last_i     (last),
    .pass_o     (pass_o),
    .miss_cnt_o (miss_cnt_o)
  );

  assign scan_en_o = run;

endmodule

// File: rtl/scan_flush_chk.sv
module scan_flush_chk #(
  parameter int MISS_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              scan_en_o,
  input logic              scan_in_o,
  input logic              done_o,
  input logic              pass_o,
  input logic [MISS_W-1:0] miss_cnt_o
);

  AST_START_ENTERS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (scan_en_o && !scan_in_o)); // R2

  AST_STREAM_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en_o && $past(scan_en_o) && $past(scan_en_o, 2) &&
     !$past(start_i) && !$past(start_i, 2)) |-> (scan_in_o != $past(scan_in_o, 2))); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!scan_en_o && $past(scan_en_o))); // R6

  AST_PASS_ZERO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> (miss_cnt_o == '0)); // R7

  AST_MISS_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start_i) |-> (miss_cnt_o >= $past(miss_cnt_o))); // R5

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (miss_cnt_o == '0 && !pass_o)); // R8

endmodule

bind scan_flush_ctrl scan_flush_chk #(.MISS_W(MISS_W)) i_scan_flush_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .scan_en_o  (scan_en_o),
  .scan_in_o  (scan_in_o),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .miss_cnt_o (miss_cnt_o)
);

// File: tb/test_scan_flush_ctrl.sv
module test_scan_flush_ctrl;

  localparam int LA = 8;
  localparam int WA = 4;
  localparam int LB = 5;
  localparam int WB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // DUT A: wide counter, fault-injectable chain
  logic          start_a = 1'b0;
  logic          en_a, sin_a, done_a, pass_a, sout_a;
  logic [WA-1:0] miss_a;
  logic [LA-1:0] cha;
  int            mode_a = 0;

  // DUT B: narrow counter, optionally inverting chain
  logic          start_b = 1'b0;
  logic          en_b, sin_b, done_b, pass_b, sout_b;
  logic [WB-1:0] miss_b;
  logic [LB-1:0] chb;
  int            mode_b = 0;

  scan_flush_ctrl #(.CHAIN_LEN(LA), .MISS_W(WA)) i_scan_flush_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_a), .scan_out_i(sout_a),
    .scan_en_o(en_a), .scan_in_o(sin_a), .done_o(done_a),
    .pass_o(pass_a), .miss_cnt_o(miss_a));

  scan_flush_ctrl #(.CHAIN_LEN(LB), .MISS_W(WB)) i_scan_flush_ctrl_b (
    .clk(clk), .rst_n(rst_n), .start_i(start_b), .scan_out_i(sout_b),
    .scan_en_o(en_b), .scan_in_o(sin_b), .done_o(done_b),
    .pass_o(pass_b), .miss_cnt_o(miss_b));

  // Behavioural chains; modes: 0 good, 1 cell 3 stuck 0, 2 cell 3 stuck 1,
  // 3 inverted output, 4 one cell short.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cha <= '1;
      chb <= '1;
    end else begin
      if (en_a) begin
        logic [LA-1:0] nx;
        nx = {cha[LA-2:0], sin_a};
        if (mode_a == 1) nx[3] = 1'b0;
        if (mode_a == 2) nx[3] = 1'b1;
        cha <= nx;
      end
      if (en_b) chb <= {chb[LB-2:0], sin_b};
    end
  end
  assign sout_a = (mode_a == 3) ? ~cha[LA-1] : (mode_a == 4) ? cha[LA-2] : cha[LA-1];
  assign sout_b = (mode_b == 1) ? ~chb[LB-1] : chb[LB-1];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int sel);
    @(negedge clk);
    if (sel == 0) start_a = 1'b1; else start_b = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    start_b = 1'b0;
  endtask

  // Called at the negedge of run cycle 0; follows the run to its end.
  task automatic follow(input int sel, input int raw_miss);
    int len, maxc, expm, n, bad;
    len  = (sel == 0) ? LA : LB;
    maxc = (sel == 0) ? (1 << WA) - 1 : (1 << WB) - 1;
    expm = (raw_miss > maxc) ? maxc : raw_miss;
    n = 0;
    bad = 0;
    chk("R2 shift mode after start", int'(sel == 0 ? en_a : en_b), 1);
    while ((sel == 0 ? en_a : en_b) && n < 200) begin
      if ((sel == 0 ? sin_a : sin_b) != ((n % 4) >= 2)) bad++;
      n++;
      @(negedge clk);
    end
    chk("R3 stream bit errors", bad, 0);
    chk("R2 shift cycles", n, len + 4);
    chk("R6 done after run", int'(sel == 0 ? done_a : done_b), 1);
    chk("R4 R5 mismatch count", int'(sel == 0 ? miss_a : miss_b), expm);
    chk("R7 pass at done", int'(sel == 0 ? pass_a : pass_b), int'(raw_miss == 0));
    repeat (3) @(negedge clk);
    chk("R6 done single cycle", int'(sel == 0 ? done_a : done_b), 0);
    chk("R7 pass held", int'(sel == 0 ? pass_a : pass_b), int'(raw_miss == 0));
    chk("R7 count held", int'(sel == 0 ? miss_a : miss_b), expm);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 scan_en", int'(en_a), 0);
    chk("R1 scan_in", int'(sin_a), 0);
    chk("R1 done", int'(done_a), 0);
    chk("R1 pass", int'(pass_a), 0);
    chk("R1 count", int'(miss_a), 0);

    // R4: chain preloaded with ones, good chain must still pass
    for (int m = 0; m < 5; m++) begin
      mode_a = m;
      pulse(0);
      follow(0, (m == 0) ? 0 : (m == 3) ? 4 : 2);
    end

    // R8: start after a failing run clears results; mid-run restart
    mode_a = 0;
    pulse(0);
    chk("R8 count cleared", int'(miss_a), 0);
    chk("R8 pass cleared", int'(pass_a), 0);
    repeat (5) @(negedge clk);
    start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    follow(0, 0);

    // R8: restart a failing run midway with a good chain
    mode_a = 3;
    pulse(0);
    repeat (LA + 1) @(negedge clk);
    mode_a = 0;
    start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    chk("R8 mid-run clear", int'(miss_a), 0);
    follow(0, 0);

    // R5 saturation on narrow counter, then good run
    mode_b = 1;
    pulse(1);
    follow(1, 4);
    mode_b = 0;
    pulse(1);
    follow(1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule